// File: doc/BRIEF.md
# Clock-Gated Multi-Port GPIO Bank

This block gives software six general-purpose I/O ports on one simple register bus. Each port has up to eight pins. For every pin there are four control bits: an output latch, a direction bit, an alternate-source select and a digital enable. A pin with its enable bit cleared stays inert. It is not driven, and it reads back as zero. A pin handed to the alternate source takes its value and its output enable from external signals instead of from the port registers. Input levels reach the data register only after a two-flop synchronizer.

A system-control register holds one clock-gate bit per port. A port answers bus accesses only when its gate bit has been set and two further bus cycles have elapsed. An access that arrives earlier is refused. It changes no state, it returns zero, and it raises a one-cycle error flag. Bus reads are registered: the read data is valid in the cycle after the access and is held until the next read.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register is 0. All pins are undriven (pin_oe = 0, pin_out = 0) and the gate register reads 0.
- R2: The gate register sits at address 0xF608. Bit k (k = 0..5) gates port k, in the order A, B, C, D, E, F. Bits 7:6 always read as 0.
- R3: If the gate write is sampled at edge E, an access sampled at edge E+1 or E+2 is refused and one sampled at E+3 or later is served. Clearing the bit refuses accesses from the next edge on.
- R4: A refused access updates no register. It returns bus_rdata = 0, and bus_err is 1 for exactly the one cycle after the access.
- R5: Port n (n = 0..5) occupies addresses n*0x1000 + offset. The offsets are 0x3FC for data, 0x400 for direction, 0x420 for alternate select and 0x51C for digital enable. Read data appears on bus_rdata one cycle after the access and is held until the next read.
- R6: A direction bit of 1 makes an enabled, non-alternate pin an output: pin_oe = 1 and pin_out = latch bit. A direction bit of 0 makes it an input: pin_oe = 0.
- R7: A pin whose digital-enable bit is 0 has pin_oe = 0 and pin_out = 0, and its bit reads as 0 in the data register.
- R8: An enabled pin whose alternate-select bit is 1 takes pin_oe from alt_oe and pin_out from alt_out, whatever its direction and latch bits hold.
- R9: A data read returns the latch bit for enabled output pins and the synchronized pin level for all other enabled pins. A level applied at pin_in first shows up in a read sampled at the third edge after it is applied.
- R10: Ports A–D have 8 pins, port E has 6 and port F has 5. The bits above a port's width read as 0, ignore writes and keep pin_oe and pin_out at 0.
- R11: Every pin with pin_oe = 0 has pin_out = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_err | output | 1 | One-cycle flag for a refused access |
| pin_in | input | 48 | Pin levels, port n at bits 8n+7..8n |
| alt_out | input | 48 | Alternate-source output values |
| alt_oe | input | 48 | Alternate-source output enables |
| pin_out | output | 48 | Pin output values |
| pin_oe | output | 48 | Pin output enables |

## Verification
Each port is tried with mixed masks: part output, part input, part disabled, part alternate. A swapped select or a dropped enable term then changes specific bits instead of the whole byte. The direction and alternate tests use masks that differ in every nibble, so they tell the latch, alt_out and the sampled level apart in one read. Input latency is shown by changing a pin level and reading on three consecutive cycles. That tells a two-stage synchronizer from one or three stages. Gate timing is probed on the first, second and third cycle after a gate write. A blocked write is followed by a readback, which shows that it left no trace. The narrow ports are written with all ones, so that a missing width mask shows.

// File: rtl/gpio_pkg.sv
// Shared constants, register decode and port geometry for the GPIO bank.
// Assumes at most REG_W pins per port and NUM_PORTS <= REG_W.
package gpio_pkg;

    localparam int NUM_PORTS    = 6;
    localparam int REG_W        = 8;
    localparam int ADDR_W       = 16;
    localparam int PORT_SEL_LSB = 12;
    localparam int OFF_W        = PORT_SEL_LSB;

    localparam logic [OFF_W-1:0]  OFF_DATA  = 12'h3FC;
    localparam logic [OFF_W-1:0]  OFF_DIR   = 12'h400;
    localparam logic [OFF_W-1:0]  OFF_ALT   = 12'h420;
    localparam logic [OFF_W-1:0]  OFF_EN    = 12'h51C;
    localparam logic [ADDR_W-1:0] GATE_ADDR = 16'hF608;

    typedef enum logic [2:0] {
        PREG_NONE,
        PREG_DATA,
        PREG_DIR,
        PREG_ALT,
        PREG_EN
    } port_reg_e;

    // Pin count of a port index; ports 4 and 5 are narrow.
    function automatic int port_width(int idx);
        case (idx)
            4:       return 6;
            5:       return 5;
            default: return 8;
        endcase
    endfunction

    // Map an in-port offset to the register it selects.
    function automatic port_reg_e decode_offset(logic [OFF_W-1:0] off);
        case (off)
            OFF_DATA: return PREG_DATA;
            OFF_DIR:  return PREG_DIR;
            OFF_ALT:  return PREG_ALT;
            OFF_EN:   return PREG_EN;
            default:  return PREG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
// Multi-stage input synchronizer for a group of pins.
// Assumes STAGES >= 2; resets every stage to 0.
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift pin levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_sysctl.sv
// Clock-gate register and per-port readiness counters.
// Assumes the gate register is always accessible; a port counts as ready
// READY_CYCLES edges after its gate bit was seen set.
module gpio_sysctl #(
    parameter int NUM_PORTS    = 6,
    parameter int REG_W        = 8,
    parameter int READY_CYCLES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wdata,
    output logic [REG_W-1:0]     gate_rd,
    output logic [NUM_PORTS-1:0] port_ready
);

    localparam int CNT_W = $clog2(READY_CYCLES + 1);

    logic [NUM_PORTS-1:0] gate_q;

    // Capture gate bits; reserved bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else if (wr_en) begin
            gate_q <= wdata[NUM_PORTS-1:0];
        end
    end

    // Zero-extend the gate bits onto the read bus.
    always_comb begin
        gate_rd = '0;
        gate_rd[NUM_PORTS-1:0] = gate_q;
    end

    if (NUM_PORTS < REG_W) begin : g_rsvd
        logic unused_rsvd;
        assign unused_rsvd = ^wdata[REG_W-1:NUM_PORTS];
    end

    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_ready
        logic [CNT_W-1:0] cnt_q;

        // Count cycles since the gate opened, saturating at the limit.
        always_ff @(posedge clk) begin
            if (!rst_n || !gate_q[gi]) begin
                cnt_q <= '0;
            end else if (cnt_q != CNT_W'(READY_CYCLES)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end

        assign port_ready[gi] = gate_q[gi] && (cnt_q == CNT_W'(READY_CYCLES));
    end

endmodule

// File: rtl/gpio_port.sv
// One GPIO port: control registers, input synchronizer and pin muxing.
// Assumes wr_en is already qualified by address hit and port readiness.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int RW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] reg_off,
    input  logic [RW-1:0]    wdata,
    output logic [RW-1:0]    rd_data,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] alt_out,
    input  logic [WIDTH-1:0] alt_oe,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);

    logic [WIDTH-1:0] latch_q, dir_q, alt_q, en_q;
    logic [WIDTH-1:0] level_s;
    logic [WIDTH-1:0] plain_out, drive_val, oe_val, data_view;
    port_reg_e        reg_sel;

    assign reg_sel = decode_offset(reg_off);

    // Update the selected control register on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
            alt_q   <= '0;
            en_q    <= '0;
        end else if (wr_en) begin
            case (reg_sel)
                PREG_DATA: latch_q <= wdata[WIDTH-1:0];
                PREG_DIR:  dir_q   <= wdata[WIDTH-1:0];
                PREG_ALT:  alt_q   <= wdata[WIDTH-1:0];
                PREG_EN:   en_q    <= wdata[WIDTH-1:0];
                default:   ;
            endcase
        end
    end

    gpio_sync #(
        .WIDTH (WIDTH),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_in),
        .q    (level_s)
    );

    // Pick each pin's source and form its enable, value and readback.
    always_comb begin
        plain_out = dir_q & ~alt_q;
        drive_val = (alt_q & alt_out) | (~alt_q & latch_q);
        oe_val    = en_q & ((alt_q & alt_oe) | plain_out);
        data_view = en_q & ((plain_out & latch_q) | (~plain_out & level_s));
    end

    assign pin_oe  = oe_val;
    assign pin_out = oe_val & drive_val;

    // Return the addressed register, zero-extended to the bus width.
    always_comb begin
        rd_data = '0;
        case (reg_sel)
            PREG_DATA: rd_data[WIDTH-1:0] = data_view;
            PREG_DIR:  rd_data[WIDTH-1:0] = dir_q;
            PREG_ALT:  rd_data[WIDTH-1:0] = alt_q;
            PREG_EN:   rd_data[WIDTH-1:0] = en_q;
            default:   rd_data = '0;
        endcase
    end

    if (WIDTH < RW) begin : g_narrow
        logic unused_wdata;
        assign unused_wdata = ^wdata[RW-1:WIDTH];
    end

endmodule

// File: rtl/gpio_bank.sv
// Top of the GPIO bank: bus decode, gate readiness check, registered read
// path and per-port instances. Assumes one access per bus_en cycle.
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int ADDR_BITS    = ADDR_W,
    parameter int DATA_BITS    = REG_W,
    parameter int PORTS        = NUM_PORTS,
    parameter int SYNC_STAGES  = 2,
    parameter int READY_CYCLES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_en,
    input  logic                       bus_we,
    input  logic [ADDR_BITS-1:0]       bus_addr,
    input  logic [DATA_BITS-1:0]       bus_wdata,
    output logic [DATA_BITS-1:0]       bus_rdata,
    output logic                       bus_err,
    input  logic [PORTS*DATA_BITS-1:0] pin_in,
    input  logic [PORTS*DATA_BITS-1:0] alt_out,
    input  logic [PORTS*DATA_BITS-1:0] alt_oe,
    output logic [PORTS*DATA_BITS-1:0] pin_out,
    output logic [PORTS*DATA_BITS-1:0] pin_oe
);

    localparam int PIDX_W = ADDR_BITS - PORT_SEL_LSB;

    logic [PIDX_W-1:0]                 port_idx;
    logic [OFF_W-1:0]                  reg_off;
    logic                              gate_hit;
    logic [PORTS-1:0]                  port_hit;
    logic [PORTS-1:0]                  port_ready;
    logic [PORTS-1:0][DATA_BITS-1:0]   port_rd;
    logic [DATA_BITS-1:0]              gate_rd;
    logic [DATA_BITS-1:0]              rd_mux;
    logic                              blocked;
    logic [DATA_BITS-1:0]              rdata_q;
    logic                              err_q;

    assign port_idx = bus_addr[ADDR_BITS-1:PORT_SEL_LSB];
    assign reg_off  = bus_addr[PORT_SEL_LSB-1:0];
    assign gate_hit = bus_en && (bus_addr == ADDR_BITS'(GATE_ADDR));

    // Work out which port an access targets.
    always_comb begin
        for (int i = 0; i < PORTS; i++) begin
            port_hit[i] = bus_en && (port_idx == PIDX_W'(i));
        end
    end

    assign blocked = |(port_hit & ~port_ready);

    gpio_sysctl #(
        .NUM_PORTS   (PORTS),
        .REG_W       (DATA_BITS),
        .READY_CYCLES(READY_CYCLES)
    ) u_sysctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (gate_hit && bus_we),
        .wdata     (bus_wdata),
        .gate_rd   (gate_rd),
        .port_ready(port_ready)
    );

    for (genvar gi = 0; gi < PORTS; gi++) begin : g_port
        localparam int W = port_width(gi);
        logic [W-1:0] p_out, p_oe;

        gpio_port #(
            .WIDTH      (W),
            .RW         (DATA_BITS),
            .SYNC_STAGES(SYNC_STAGES)
        ) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (port_hit[gi] && port_ready[gi] && bus_we),
            .reg_off(reg_off),
            .wdata  (bus_wdata),
            .rd_data(port_rd[gi]),
            .pin_in (pin_in[gi*DATA_BITS +: W]),
            .alt_out(alt_out[gi*DATA_BITS +: W]),
            .alt_oe (alt_oe[gi*DATA_BITS +: W]),
            .pin_out(p_out),
            .pin_oe (p_oe)
        );

        assign pin_out[gi*DATA_BITS +: W] = p_out;
        assign pin_oe[gi*DATA_BITS +: W]  = p_oe;

        if (W < DATA_BITS) begin : g_pad
            logic unused_pad;
            assign pin_out[gi*DATA_BITS+W +: DATA_BITS-W] = '0;
            assign pin_oe[gi*DATA_BITS+W +: DATA_BITS-W]  = '0;
            assign unused_pad = ^{pin_in[gi*DATA_BITS+W +: DATA_BITS-W],
                                  alt_out[gi*DATA_BITS+W +: DATA_BITS-W],
                                  alt_oe[gi*DATA_BITS+W +: DATA_BITS-W]};
        end
    end

    // Select read data from the gate register or a ready port.
    always_comb begin
        rd_mux = '0;
        if (gate_hit) begin
            rd_mux = gate_rd;
        end
        for (int i = 0; i < PORTS; i++) begin
            if (port_hit[i] && port_ready[i]) begin
                rd_mux = port_rd[i];
            end
        end
    end

    // Register read data on reads and flag refused accesses for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= blocked;
            if (bus_en && !bus_we) begin
                rdata_q <= rd_mux;
            end
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_err   = err_q;

endmodule

// File: rtl/gpio_bank_chk.sv
// Protocol checker for the GPIO bank, attached by bind.
// Assumes reset is held low at time zero.
module gpio_bank_chk #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int PW = 48
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_en,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_rdata,
    input logic          bus_err,
    input logic [PW-1:0] pin_out,
    input logic [PW-1:0] pin_oe
);

    AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_en)) else $error("err without access"); // R4

    AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && $past(!bus_we)) |-> (bus_rdata == '0)) else $error("refused read nonzero"); // R4

    AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0)) else $error("undriven pin high"); // R11

    AST_GATE_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_en && !bus_we && bus_addr == 16'hF608) |-> (bus_rdata[7:6] == 2'b00))
        else $error("reserved gate bits set"); // R2

    AST_NARROW_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_en && !bus_we && bus_addr[15:12] == 4'd5) |-> (bus_rdata[7:5] == 3'b000))
        else $error("port F upper bits set"); // R10

endmodule

bind gpio_bank gpio_bank_chk #(
    .AW(ADDR_BITS),
    .DW(DATA_BITS),
    .PW(PORTS*DATA_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .bus_err  (bus_err),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
);

// File: tb/sim_gpio_bank.sv
// Directed bench for the GPIO bank: one task per scenario.
module sim_gpio_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_err;
    logic [47:0] pin_in = '0;
    logic [47:0] alt_out = '0;
    logic [47:0] alt_oe = '0;
    logic [47:0] pin_out;
    logic [47:0] pin_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [15:0] GATE = 16'hF608;
    localparam logic [11:0] O_DATA = 12'h3FC;
    localparam logic [11:0] O_DIR  = 12'h400;
    localparam logic [11:0] O_ALT  = 12'h420;
    localparam logic [11:0] O_EN   = 12'h51C;

    always #5 clk = ~clk;

    gpio_bank u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .bus_err  (bus_err),
        .pin_in   (pin_in),
        .alt_out  (alt_out),
        .alt_oe   (alt_oe),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    function automatic logic [15:0] ra(int port, logic [11:0] off);
        return {4'(port), off};
    endfunction

    task automatic check(string req, logic [47:0] act, logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge.
    task automatic bus_write(logic [15:0] a, logic [7:0] d, output logic err);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        err = bus_err;
    endtask

    task automatic bus_read(logic [15:0] a, output logic [7:0] d, output logic err);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
        err = bus_err;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d; logic e;
        check("R1 pin_oe", pin_oe, '0);
        check("R1 pin_out", pin_out, '0);
        bus_read(GATE, d, e);
        check("R1 gate", d, 8'h00);
        bus_read(ra(0, O_DIR), d, e);
        check("R4 gated err", e, 1'b1);
        check("R4 gated data", d, 8'h00);
        idle(1);
        check("R4 err one cycle", bus_err, 1'b0);
    endtask

    task automatic t_gate_timing();
        logic [7:0] d; logic e;
        bus_write(GATE, 8'h01, e);
        bus_read(ra(0, O_DIR), d, e);
        check("R3 edge+1 refused", e, 1'b1);
        bus_read(ra(0, O_DIR), d, e);
        check("R3 edge+2 refused", e, 1'b1);
        bus_read(ra(0, O_DIR), d, e);
        check("R3 edge+3 served", e, 1'b0);
        bus_write(GATE, 8'hFF, e);
        bus_read(GATE, d, e);
        check("R2 reserved bits", d, 8'h3F);
        idle(2);
    endtask

    task automatic t_direction();
        logic [7:0] d; logic e;
        pin_in[7:0] = 8'h3C;
        bus_write(ra(0, O_EN), 8'hFF, e);
        bus_write(ra(0, O_DIR), 8'h0F, e);
        bus_write(ra(0, O_DATA), 8'hA5, e);
        idle(3);
        check("R6 oe", pin_oe[7:0], 8'h0F);
        check("R6 out", pin_out[7:0], 8'h05);
        bus_read(ra(0, O_DATA), d, e);
        check("R9 mixed read", d, 8'h35);
        bus_read(ra(0, O_DIR), d, e);
        check("R5 dir readback", d, 8'h0F);
    endtask

    task automatic t_enable();
        logic [7:0] d; logic e;
        bus_write(ra(1, O_DIR), 8'hFF, e);
        bus_write(ra(1, O_DATA), 8'hFF, e);
        bus_write(ra(1, O_EN), 8'h0F, e);
        check("R7 oe masked", pin_oe[15:8], 8'h0F);
        check("R7 out masked", pin_out[15:8], 8'h0F);
        bus_write(ra(1, O_DIR), 8'h00, e);
        pin_in[15:8] = 8'hFF;
        idle(3);
        check("R7 inputs undriven", pin_oe[15:8], 8'h00);
        bus_read(ra(1, O_DATA), d, e);
        check("R7 disabled read zero", d, 8'h0F);
    endtask

    task automatic t_alternate();
        logic [7:0] d; logic e;
        pin_in[23:16]  = 8'h00;
        alt_out[23:16] = 8'hAA;
        alt_oe[23:16]  = 8'hCC;
        bus_write(ra(2, O_EN), 8'hFF, e);
        bus_write(ra(2, O_DIR), 8'h0F, e);
        bus_write(ra(2, O_DATA), 8'hFF, e);
        bus_write(ra(2, O_ALT), 8'hF0, e);
        idle(2);
        check("R8 oe", pin_oe[23:16], 8'hCF);
        check("R8 out", pin_out[23:16], 8'h8F);
        bus_read(ra(2, O_ALT), d, e);
        check("R5 alt readback", d, 8'hF0);
        bus_read(ra(2, O_DATA), d, e);
        check("R9 alt pins read level", d, 8'h0F);
    endtask

    task automatic t_narrow();
        logic [7:0] d; logic e;
        bus_write(ra(4, O_DIR), 8'hFF, e);
        bus_read(ra(4, O_DIR), d, e);
        check("R10 port E width", d, 8'h3F);
        bus_write(ra(5, O_DIR), 8'hFF, e);
        bus_write(ra(5, O_EN), 8'hFF, e);
        bus_write(ra(5, O_DATA), 8'hFF, e);
        bus_read(ra(5, O_DIR), d, e);
        check("R10 port F width", d, 8'h1F);
        check("R10 port F oe", pin_oe[47:40], 8'h1F);
        check("R10 port F out", pin_out[47:40], 8'h1F);
    endtask

    task automatic t_sync();
        logic [7:0] d; logic e;
        pin_in[31:24] = 8'h00;
        bus_write(ra(3, O_EN), 8'hFF, e);
        idle(3);
        pin_in[31:24] = 8'h5A;
        bus_read(ra(3, O_DATA), d, e);
        check("R9 first edge old", d, 8'h00);
        bus_read(ra(3, O_DATA), d, e);
        check("R9 second edge old", d, 8'h00);
        bus_read(ra(3, O_DATA), d, e);
        check("R9 third edge new", d, 8'h5A);
    endtask

    task automatic t_blocked();
        logic [7:0] d; logic e;
        bus_write(GATE, 8'h3E, e);
        bus_write(ra(0, O_DIR), 8'hFF, e);
        check("R3 cleared gate refuses", e, 1'b1);
        bus_read(ra(0, O_DIR), d, e);
        check("R4 refused read zero", d, 8'h00);
        bus_write(GATE, 8'h3F, e);
        idle(2);
        bus_read(ra(0, O_DIR), d, e);
        check("R4 blocked write kept", d, 8'h0F);
        check("R4 no err when ready", e, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gate_timing();
        t_direction();
        t_enable();
        t_alternate();
        t_narrow();
        t_sync();
        t_blocked();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule